// File: doc/BRIEF.md
# Pulse-Keyed Programming Mode Controller

This block is the sequencer behind a single-pin trim programming scheme. An upstream qualifier turns the pin voltage into three kinds of one-cycle strobes: a mid-level pulse, a high-level pulse and a long blow pulse. The controller counts mid pulses between high-pulse delimiters to pick a mode (blow/lock, try or read), then a parameter register (sensitivity, offset with clamp disable, factory trim, margin/lock). It then addresses a bitfield inside that register.

In try mode the controller keeps volatile trim codes for the sensitivity and offset registers. It ORs each code with the matching fuse-bank value to drive the trim outputs, so a user can step a parameter and measure the result before anything is made permanent. In blow mode the addressing count selects a single fuse bit. A blow strobe sends a one-cycle request to the separate fuse bank, and the controller then refuses all further events until power is cycled. In read mode it enables read-back from the fuse bank of the addressed bit. The active-low reset stands for a supply cycle.

Top module: `pulse_prog_ctrl`

## Requirements
- R1: After reset, mode_key, param_key and addr_count are 0, fuse_blow_req, fuse_rd_en and pwr_cycle_req are low, and the controller waits in its initial state. In that state mid strobes have no effect on mode_key.
- R2: A high strobe from the initial state starts mode selection. Each mid strobe there increments mode_key, which saturates at 3. Key 1 means blow/lock, key 2 means try and key 3 means read.
- R3: Two further high strobes end mode selection and start parameter selection. If mode_key is 0 at that point, the controller goes idle and ignores every event until reset.
- R4: Entering parameter selection clears param_key and addr_count. Each mid strobe increments param_key, which saturates at 4. Key 1 means sensitivity, 2 offset, 3 factory trim and 4 margin/lock. A high strobe enters addressing, unless param_key is 0, in which case the controller goes idle until reset.
- R5: In try addressing each mid strobe increments addr_count. The count saturates at 2^W-1 for the register's width W, which gives 127 for sensitivity and 63 for offset. The count is held as that register's try code.
- R6: In try addressing a high strobe returns to parameter selection. The try codes are kept. Addressing the same register again resumes from its kept code.
- R7: In blow addressing, mid strobes step addr_count (the bit index), saturating at W-1, and high strobes are ignored. A blow strobe raises fuse_blow_req for exactly one cycle, with addr_count and param_key naming the fuse. pwr_cycle_req then stays high and every later event is ignored.
- R8: In read addressing fuse_rd_en is high and mid strobes step the bit index, saturating at W-1. A high strobe returns to parameter selection and drops fuse_rd_en.
- R9: trim_sens is fuse_sens OR the sensitivity try code, and trim_offs is fuse_offs OR the offset try code.
- R10: When strobes coincide, blow takes precedence over high and high over mid. A blow strobe outside blow-mode addressing has no effect.
- R11: Reset clears both try codes, so each trim output falls back to its fuse value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply cycle) |
| evt_mid | input | 1 | Qualified mid-level pulse strobe |
| evt_high | input | 1 | Qualified high-level pulse strobe |
| evt_blow | input | 1 | Qualified blow pulse strobe |
| fuse_sens | input | SENS_W | Fuse-bank sensitivity value |
| fuse_offs | input | OFFS_W | Fuse-bank offset value |
| mode_key | output | 2 | Counted mode key |
| param_key | output | 3 | Counted parameter key |
| addr_count | output | ADDR_W | Addressing count (code or bit index) |
| trim_sens | output | SENS_W | Effective sensitivity trim |
| trim_offs | output | OFFS_W | Effective offset trim |
| fuse_blow_req | output | 1 | One-cycle blow request to the fuse bank |
| fuse_rd_en | output | 1 | Read-back enable to the fuse bank |
| pwr_cycle_req | output | 1 | Blow done; supply cycle needed |

## Verification
The embedded properties assume that every strobe is synchronous to clk and lasts a single cycle. The bench drives each event for one cycle and follows it with an idle cycle, so every registered output has settled before it is sampled. Coincident strobes are applied only in the precedence test. The fuse inputs are treated as quasi-static: the bench changes them only between events and waits a cycle before checking the trim outputs.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_MODE,
    ST_GAP,
    ST_PARAM,
    ST_ADDR,
    ST_DEAD,
    ST_IDLE
  } seq_state_t;

  localparam int MKEY_W = 2;
  localparam int PKEY_W = 3;

  localparam logic [MKEY_W-1:0] MK_BLOW = 2'd1;
  localparam logic [MKEY_W-1:0] MK_TRY  = 2'd2;
  localparam logic [MKEY_W-1:0] MK_READ = 2'd3;
  localparam logic [MKEY_W-1:0] MKEY_MAX = 2'd3;

  localparam logic [PKEY_W-1:0] PK_SENS = 3'd1;
  localparam logic [PKEY_W-1:0] PK_OFFS = 3'd2;
  localparam logic [PKEY_W-1:0] PK_FAC  = 3'd3;
  localparam logic [PKEY_W-1:0] PK_MRG  = 3'd4;
  localparam logic [PKEY_W-1:0] PKEY_MAX = 3'd4;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ppc_sat_counter.sv
module ppc_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  input  logic [W-1:0] cap,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (clr) begin
      q_n = '0;
    end else if (load) begin
      q_n = load_val;
    end else if (inc && (q_r < cap)) begin
      q_n = q_r + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_n;
    end
  end

  assign q = q_r;

  AST_SAT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !load && (q_r <= cap)) |=> (q_r <= $past(cap))); // R5

endmodule

// File: rtl/ppc_try_reg.sv
module ppc_try_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (wr) begin
      q_r <= d;
    end
  end

  assign q = q_r;

  AST_TRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q_r)); // R6

endmodule

// File: rtl/ppc_seq.sv
module ppc_seq
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_mid,
  input  logic              ev_high,
  input  logic              ev_blow,
  input  logic [MKEY_W-1:0] mode_key,
  input  logic [PKEY_W-1:0] param_key,
  output seq_state_t        state,
  output logic              mkey_inc,
  output logic              pkey_clr,
  output logic              pkey_inc,
  output logic              addr_clr,
  output logic              addr_load,
  output logic              addr_inc,
  output logic              blow_fire
);

  seq_state_t st_r;
  seq_state_t st_n;

  always_comb begin
    st_n      = st_r;
    mkey_inc  = 1'b0;
    pkey_clr  = 1'b0;
    pkey_inc  = 1'b0;
    addr_clr  = 1'b0;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    blow_fire = 1'b0;
    case (st_r)
      ST_INIT: begin
        if (ev_high) st_n = ST_MODE;
      end
      ST_MODE: begin
        if (ev_high) st_n = ST_GAP;
        else if (ev_mid) mkey_inc = 1'b1;
      end
      ST_GAP: begin
        if (ev_high) begin
          if (mode_key == '0) begin
            st_n = ST_IDLE;
          end else begin
            st_n     = ST_PARAM;
            pkey_clr = 1'b1;
            addr_clr = 1'b1;
          end
        end
      end
      ST_PARAM: begin
        if (ev_high) begin
          if (param_key == '0) begin
            st_n = ST_IDLE;
          end else begin
            st_n      = ST_ADDR;
            addr_load = 1'b1;
          end
        end else if (ev_mid) begin
          pkey_inc = 1'b1;
        end
      end
      ST_ADDR: begin
        if (mode_key == MK_BLOW) begin
          if (ev_blow) begin
            blow_fire = 1'b1;
            st_n      = ST_DEAD;
          end else if (ev_mid) begin
            addr_inc = 1'b1;
          end
        end else begin
          if (ev_high) begin
            st_n     = ST_PARAM;
            pkey_clr = 1'b1;
            addr_clr = 1'b1;
          end else if (ev_mid) begin
            addr_inc = 1'b1;
          end
        end
      end
      ST_DEAD: st_n = ST_DEAD;
      ST_IDLE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r <= ST_INIT;
    end else begin
      st_r <= st_n;
    end
  end

  assign state = st_r;

  AST_INIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r == ST_INIT && !ev_high) |=> (st_r == ST_INIT)); // R1

  AST_DEAD_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r == ST_DEAD) |=> (st_r == ST_DEAD)); // R7

  AST_IDLE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r == ST_IDLE) |=> (st_r == ST_IDLE)); // R3

  AST_BLOW_ONLY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_r != ST_ADDR) |=> (st_r != ST_DEAD || $past(st_r) == ST_DEAD)); // R10

endmodule

// File: rtl/pulse_prog_ctrl.sv
module pulse_prog_ctrl
  import ppc_pkg::*;
#(
  parameter int SENS_W = 7,
  parameter int OFFS_W = 6,
  parameter int FAC_W  = 4,
  parameter int MRG_W  = 4,
  localparam int ADDR_W = ppc_pkg::max4(SENS_W, OFFS_W, FAC_W, MRG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_mid,
  input  logic              evt_high,
  input  logic              evt_blow,
  input  logic [SENS_W-1:0] fuse_sens,
  input  logic [OFFS_W-1:0] fuse_offs,
  output logic [1:0]        mode_key,
  output logic [2:0]        param_key,
  output logic [ADDR_W-1:0] addr_count,
  output logic [SENS_W-1:0] trim_sens,
  output logic [OFFS_W-1:0] trim_offs,
  output logic              fuse_blow_req,
  output logic              fuse_rd_en,
  output logic              pwr_cycle_req
);

  localparam logic [ADDR_W-1:0] TRY_CAP_SENS = ADDR_W'((1 << SENS_W) - 1);
  localparam logic [ADDR_W-1:0] TRY_CAP_OFFS = ADDR_W'((1 << OFFS_W) - 1);
  localparam logic [ADDR_W-1:0] TRY_CAP_FAC  = ADDR_W'((1 << FAC_W) - 1);
  localparam logic [ADDR_W-1:0] TRY_CAP_MRG  = ADDR_W'((1 << MRG_W) - 1);
  localparam logic [ADDR_W-1:0] BIT_CAP_SENS = ADDR_W'(SENS_W - 1);
  localparam logic [ADDR_W-1:0] BIT_CAP_OFFS = ADDR_W'(OFFS_W - 1);
  localparam logic [ADDR_W-1:0] BIT_CAP_FAC  = ADDR_W'(FAC_W - 1);
  localparam logic [ADDR_W-1:0] BIT_CAP_MRG  = ADDR_W'(MRG_W - 1);

  // resolved strobes: blow over high over mid
  logic ev_blow;
  logic ev_high;
  logic ev_mid;

  assign ev_blow = evt_blow;
  assign ev_high = evt_high & ~evt_blow;
  assign ev_mid  = evt_mid & ~evt_high & ~evt_blow;

  seq_state_t        state;
  logic              mkey_inc;
  logic              pkey_clr;
  logic              pkey_inc;
  logic              addr_clr;
  logic              addr_load;
  logic              addr_inc;
  logic              blow_fire;
  logic [MKEY_W-1:0] mkey_q;
  logic [PKEY_W-1:0] pkey_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_cap;
  logic [ADDR_W-1:0] addr_seed;
  logic [SENS_W-1:0] try_sens;
  logic [OFFS_W-1:0] try_offs;
  logic              in_try_addr;
  logic              wr_sens;
  logic              wr_offs;
  logic              blow_req_r;

  ppc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_mid    (ev_mid),
    .ev_high   (ev_high),
    .ev_blow   (ev_blow),
    .mode_key  (mkey_q),
    .param_key (pkey_q),
    .state     (state),
    .mkey_inc  (mkey_inc),
    .pkey_clr  (pkey_clr),
    .pkey_inc  (pkey_inc),
    .addr_clr  (addr_clr),
    .addr_load (addr_load),
    .addr_inc  (addr_inc),
    .blow_fire (blow_fire)
  );

  ppc_sat_counter #(.W(MKEY_W)) u_mkey (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (1'b0),
    .load     (1'b0),
    .load_val ('0),
    .inc      (mkey_inc),
    .cap      (MKEY_MAX),
    .q        (mkey_q)
  );

  ppc_sat_counter #(.W(PKEY_W)) u_pkey (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pkey_clr),
    .load     (1'b0),
    .load_val ('0),
    .inc      (pkey_inc),
    .cap      (PKEY_MAX),
    .q        (pkey_q)
  );

  // per-register addressing limit: full code in try, top bit index otherwise
  always_comb begin
    addr_cap = '0;
    if (mkey_q == MK_TRY) begin
      case (pkey_q)
        PK_SENS: addr_cap = TRY_CAP_SENS;
        PK_OFFS: addr_cap = TRY_CAP_OFFS;
        PK_FAC:  addr_cap = TRY_CAP_FAC;
        PK_MRG:  addr_cap = TRY_CAP_MRG;
        default: addr_cap = '0;
      endcase
    end else begin
      case (pkey_q)
        PK_SENS: addr_cap = BIT_CAP_SENS;
        PK_OFFS: addr_cap = BIT_CAP_OFFS;
        PK_FAC:  addr_cap = BIT_CAP_FAC;
        PK_MRG:  addr_cap = BIT_CAP_MRG;
        default: addr_cap = '0;
      endcase
    end
  end

  // resume point when entering addressing
  always_comb begin
    addr_seed = '0;
    if (mkey_q == MK_TRY) begin
      if (pkey_q == PK_SENS) addr_seed = ADDR_W'(try_sens);
      else if (pkey_q == PK_OFFS) addr_seed = ADDR_W'(try_offs);
    end
  end

  ppc_sat_counter #(.W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (addr_clr),
    .load     (addr_load),
    .load_val (addr_seed),
    .inc      (addr_inc),
    .cap      (addr_cap),
    .q        (addr_q)
  );

  assign in_try_addr = (state == ST_ADDR) && (mkey_q == MK_TRY);
  assign wr_sens     = in_try_addr && (pkey_q == PK_SENS);
  assign wr_offs     = in_try_addr && (pkey_q == PK_OFFS);

  ppc_try_reg #(.W(SENS_W)) u_try_sens (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_sens),
    .d     (addr_q[SENS_W-1:0]),
    .q     (try_sens)
  );

  ppc_try_reg #(.W(OFFS_W)) u_try_offs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_offs),
    .d     (addr_q[OFFS_W-1:0]),
    .q     (try_offs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blow_req_r <= 1'b0;
    end else begin
      blow_req_r <= blow_fire;
    end
  end

  assign mode_key      = mkey_q;
  assign param_key     = pkey_q;
  assign addr_count    = addr_q;
  assign trim_sens     = fuse_sens | try_sens;
  assign trim_offs     = fuse_offs | try_offs;
  assign fuse_blow_req = blow_req_r;
  assign fuse_rd_en    = (state == ST_ADDR) && (mkey_q == MK_READ);
  assign pwr_cycle_req = (state == ST_DEAD);

  AST_BLOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_blow_req |=> (!fuse_blow_req && pwr_cycle_req)); // R7

  AST_BLOW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle_req |=> ($stable(addr_count) && $stable(param_key) && $stable(mode_key))); // R7

  AST_RD_NOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd_en |-> !pwr_cycle_req); // R8

endmodule

// File: tb/tb_pulse_prog_ctrl.sv
module tb_pulse_prog_ctrl;

  logic       clk;
  logic       rst_n;
  logic       evt_mid;
  logic       evt_high;
  logic       evt_blow;
  logic [6:0] fuse_sens;
  logic [5:0] fuse_offs;
  logic [1:0] mode_key;
  logic [2:0] param_key;
  logic [6:0] addr_count;
  logic [6:0] trim_sens;
  logic [5:0] trim_offs;
  logic       fuse_blow_req;
  logic       fuse_rd_en;
  logic       pwr_cycle_req;

  int n_run;
  int n_fail;

  pulse_prog_ctrl dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_mid       (evt_mid),
    .evt_high      (evt_high),
    .evt_blow      (evt_blow),
    .fuse_sens     (fuse_sens),
    .fuse_offs     (fuse_offs),
    .mode_key      (mode_key),
    .param_key     (param_key),
    .addr_count    (addr_count),
    .trim_sens     (trim_sens),
    .trim_offs     (trim_offs),
    .fuse_blow_req (fuse_blow_req),
    .fuse_rd_en    (fuse_rd_en),
    .pwr_cycle_req (pwr_cycle_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // event codes used by the bench: 1 mid, 2 high, 3 blow, 4 mid+high
  localparam int EV_MID  = 1;
  localparam int EV_HIGH = 2;
  localparam int EV_BLOW = 3;
  localparam int EV_MH   = 4;

  // vector: {event[1:0], mode_key[1:0], param_key[2:0], addr_count[6:0], pwr}
  localparam int NVEC = 20;
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd2, 2'd0, 3'd0, 7'd0, 1'b0},
    {2'd1, 2'd1, 3'd0, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd0, 7'd0, 1'b0},
    {2'd2, 2'd2, 3'd0, 7'd0, 1'b0},
    {2'd2, 2'd2, 3'd0, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd0, 1'b0},
    {2'd2, 2'd2, 3'd1, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd1, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd2, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd3, 1'b0},
    {2'd2, 2'd2, 3'd0, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd2, 7'd0, 1'b0},
    {2'd2, 2'd2, 3'd2, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd2, 7'd1, 1'b0},
    {2'd1, 2'd2, 3'd2, 7'd2, 1'b0},
    {2'd2, 2'd2, 3'd0, 7'd0, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd0, 1'b0},
    {2'd2, 2'd2, 3'd1, 7'd3, 1'b0},
    {2'd1, 2'd2, 3'd1, 7'd4, 1'b0}
  };

  logic [14:0] vec;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe cycle, one idle cycle; returns at a falling edge
  task automatic ev(input int k);
    @(negedge clk);
    evt_mid  = (k == EV_MID) || (k == EV_MH);
    evt_high = (k == EV_HIGH) || (k == EV_MH);
    evt_blow = (k == EV_BLOW);
    @(posedge clk);
    @(negedge clk);
    evt_mid  = 1'b0;
    evt_high = 1'b0;
    evt_blow = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic evn(input int k, input int n);
    for (int i = 0; i < n; i++) ev(k);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run     = 0;
    n_fail    = 0;
    evt_mid   = 1'b0;
    evt_high  = 1'b0;
    evt_blow  = 1'b0;
    fuse_sens = '0;
    fuse_offs = '0;
    rst_n     = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 mode_key", mode_key, 0);
    chk("R1 param_key", param_key, 0);
    chk("R1 addr_count", addr_count, 0);
    chk("R1 flags", {fuse_blow_req, fuse_rd_en, pwr_cycle_req}, 0);
    chk("R11 trim_sens", trim_sens, 0);

    // vector table: try mode, two registers, resume
    for (int i = 0; i < NVEC; i++) begin
      vec = VEC[i];
      ev(int'(vec[14:13]));
      chk($sformatf("R2/R5/R6 vec%0d mode", i), mode_key, vec[12:11]);
      chk($sformatf("R4/R6 vec%0d pkey", i), param_key, vec[10:8]);
      chk($sformatf("R5/R6 vec%0d addr", i), addr_count, vec[7:1]);
      chk($sformatf("R7 vec%0d pwr", i), pwr_cycle_req, vec[0]);
    end
    chk("R6 try sens kept", trim_sens, 4);
    chk("R6 try offs kept", trim_offs, 2);

    // R9 OR with fuse bank
    fuse_sens = 7'h40;
    fuse_offs = 6'h20;
    @(negedge clk);
    chk("R9 trim_sens", trim_sens, 68);
    chk("R9 trim_offs", trim_offs, 34);

    // R10 mid+high together: high wins, leaves try addressing
    ev(EV_MH);
    chk("R10 precedence pkey", param_key, 0);
    chk("R10 precedence addr", addr_count, 0);
    chk("R10 sens unchanged", trim_sens, 68);

    // R11 reset clears try codes
    do_reset();
    chk("R11 sens to fuse", trim_sens, 64);
    chk("R11 offs to fuse", trim_offs, 32);
    fuse_sens = '0;
    fuse_offs = '0;

    // R1 mid ignored in initial state
    do_reset();
    evn(EV_MID, 2);
    chk("R1 mid ignored", mode_key, 0);
    ev(EV_HIGH);
    ev(EV_MID);
    chk("R2 counting after high", mode_key, 1);

    // R5 saturation in try mode
    do_reset();
    ev(EV_HIGH); evn(EV_MID, 2); ev(EV_HIGH); ev(EV_HIGH);
    ev(EV_MID); ev(EV_HIGH);
    evn(EV_MID, 130);
    chk("R5 sens saturates", addr_count, 127);
    chk("R5 sens trim", trim_sens, 127);
    ev(EV_HIGH); evn(EV_MID, 2); ev(EV_HIGH);
    evn(EV_MID, 70);
    chk("R5 offs saturates", addr_count, 63);
    chk("R5 offs trim", trim_offs, 63);

    // R2/R4 key saturation, R8 read mode
    do_reset();
    ev(EV_HIGH); evn(EV_MID, 5);
    chk("R2 mode_key saturates", mode_key, 3);
    ev(EV_HIGH); ev(EV_HIGH); evn(EV_MID, 6);
    chk("R4 param_key saturates", param_key, 4);
    ev(EV_HIGH);
    chk("R8 read enable", fuse_rd_en, 1);
    evn(EV_MID, 5);
    chk("R8 bit index saturates", addr_count, 3);
    ev(EV_BLOW);
    chk("R10 blow ignored pwr", pwr_cycle_req, 0);
    chk("R10 blow ignored req", fuse_blow_req, 0);
    chk("R10 blow ignored addr", addr_count, 3);
    ev(EV_HIGH);
    chk("R8 back to param pkey", param_key, 0);
    chk("R8 read enable drops", fuse_rd_en, 0);

    // R7 blow mode
    do_reset();
    ev(EV_HIGH); ev(EV_MID); ev(EV_HIGH); ev(EV_HIGH);
    evn(EV_MID, 2); ev(EV_HIGH);
    chk("R7 blow addr start", addr_count, 0);
    chk("R7 no read in blow", fuse_rd_en, 0);
    ev(EV_HIGH);
    evn(EV_MID, 7);
    chk("R7 high ignored, index saturates", addr_count, 5);
    chk("R7 key held", param_key, 2);
    @(negedge clk);
    evt_blow = 1'b1;
    @(posedge clk);
    @(negedge clk);
    evt_blow = 1'b0;
    chk("R7 blow request", fuse_blow_req, 1);
    chk("R7 blow bit", addr_count, 5);
    chk("R7 power cycle flag", pwr_cycle_req, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 request one cycle", fuse_blow_req, 0);
    ev(EV_MID); ev(EV_HIGH); ev(EV_BLOW);
    chk("R7 frozen addr", addr_count, 5);
    chk("R7 frozen pkey", param_key, 2);
    chk("R7 no second blow", fuse_blow_req, 0);
    chk("R7 flag sticks", pwr_cycle_req, 1);

    // R3 zero mode key
    do_reset();
    evn(EV_HIGH, 3);
    ev(EV_MID); ev(EV_HIGH); ev(EV_MID);
    chk("R3 idle pkey", param_key, 0);
    chk("R3 idle mode", mode_key, 0);
    chk("R3 idle addr", addr_count, 0);

    // R4 zero parameter key
    do_reset();
    ev(EV_HIGH); evn(EV_MID, 2); evn(EV_HIGH, 3);
    ev(EV_MID);
    chk("R4 idle pkey", param_key, 0);
    ev(EV_HIGH); ev(EV_MID);
    chk("R4 idle addr", addr_count, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule